// File: doc/BRIEF.md
# PS/2 Keyboard Key-State Decoder

This block listens to a PS/2 keyboard's clock and data lines and keeps one level output per key for a small, fixed set of keys. Each output reads high from the moment the key's make code arrives until its release sequence arrives. The release sequence is the break prefix 0xF0 followed by the make code. A keyboard resends the make code of a held key at intervals. The decoder sets each key's output and leaves the other outputs alone, so a game or control panel can read several held keys at the same time.

Both PS/2 lines pass through two-flop synchronisers into the system clock domain, and the decoder detects PS/2 clock falling edges there. Every falling edge shifts one data bit into an eleven-bit register that is preloaded with ones. When the start bit (a 0) reaches the low end of the register, the eight data bits above it are taken as the code byte and the register is reloaded. The decoder does not check parity or the stop bit. It does not handle host commands or extended-code prefixes.

Top module: `ps2_key_decoder`

## Requirements
- R1: After reset, all six key outputs are low.
- R2: A frame is one start bit (0), eight data bits least significant first, a parity bit and a stop bit, each sampled on a falling edge of ps2_clk. Changes on ps2_data while ps2_clk is high have no effect. The code byte is taken once the start bit has passed through all eleven positions. A wrong parity bit or a stop bit of 0 does not change how the frame is decoded.
- R3: The key table is key_up = 0x75, key_down = 0x72, key_left = 0x6B, key_right = 0x74, key_pad0 = 0x70 and key_space = 0x29.
- R4: A table code that does not follow 0xF0 drives its key output high. Receiving that code again leaves the output high.
- R5: A code byte that follows 0xF0 drives its key output low and never drives it high. The 0xF0 byte by itself changes no output.
- R6: The break prefix applies only to the next code byte. That byte clears the pending release even when the byte is not in the table.
- R7: A code byte that is neither in the table nor 0xF0 leaves all key outputs unchanged.
- R8: Key outputs are independent. Pressing or releasing one key does not change any other key's output, so several keys can be high at once.
- R9: A complete frame produces exactly one decoded code byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk | input | 1 | PS/2 clock line from the keyboard, asynchronous |
| ps2_data | input | 1 | PS/2 data line from the keyboard, asynchronous |
| key_up | output | 1 | High while the 0x75 key is held |
| key_down | output | 1 | High while the 0x72 key is held |
| key_left | output | 1 | High while the 0x6B key is held |
| key_right | output | 1 | High while the 0x74 key is held |
| key_pad0 | output | 1 | High while the 0x70 key is held |
| key_space | output | 1 | High while the 0x29 key is held |

## Verification
The hardest state to reach from the ports is the pending release meeting a byte that is not in the table. In that case nothing visible changes, and the consumed prefix only shows up one frame later, when a following make code must set its key. The bench sweeps all 256 code bytes through a press, a repeat, a bare prefix and a release. It then sends a prefix, an unknown byte and a make code in that order. Along the way it uses wrong parity, a zero stop bit and data glitches while the clock is high, so the sweep also confirms that framing ignores those bits.

// File: rtl/ps2kd_pkg.sv
package ps2kd_pkg;

  localparam int KEY_COUNT  = 6;
  localparam int FRAME_BITS = 11;
  localparam int CODE_BITS  = 8;
  localparam logic [CODE_BITS-1:0] RELEASE_PREFIX = 8'hF0;

  // Code assigned to each key output index.
  function automatic logic [CODE_BITS-1:0] key_code(input int idx);
    case (idx)
      0:       key_code = 8'h75; // up
      1:       key_code = 8'h72; // down
      2:       key_code = 8'h6B; // left
      3:       key_code = 8'h74; // right
      4:       key_code = 8'h70; // keypad zero
      5:       key_code = 8'h29; // space
      default: key_code = 8'h00;
    endcase
  endfunction

  function automatic logic is_key_code(input logic [CODE_BITS-1:0] b);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < KEY_COUNT; i++) begin
      if (b == key_code(i)) hit = 1'b1;
    end
    return hit;
  endfunction

  // The start bit is the only 0 that can reach the bottom of a ones-preloaded register.
  function automatic logic frame_complete(input logic [FRAME_BITS-1:0] sr);
    return ~sr[0];
  endfunction

  // Data bits sit directly above the start bit, LSB first.
  function automatic logic [CODE_BITS-1:0] frame_byte(input logic [FRAME_BITS-1:0] sr);
    return sr[CODE_BITS:1];
  endfunction

endpackage

// File: rtl/ps2kd_sync.sv
module ps2kd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ps2kd_framer.sv
module ps2kd_framer
  import ps2kd_pkg::*;
#(
  parameter int WIDTH = FRAME_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pclk_s,
  input  logic                 pdat_s,
  output logic                 fall_evt,
  output logic                 frame_done,
  output logic [CODE_BITS-1:0] code_byte
);
  logic             pclk_prev;
  logic [WIDTH-1:0] shreg;

  assign fall_evt   = pclk_prev & ~pclk_s;
  assign frame_done = frame_complete(shreg);
  assign code_byte  = frame_byte(shreg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pclk_prev <= 1'b1;
      shreg     <= '1;
    end else begin
      pclk_prev <= pclk_s;
      if (frame_done)
        shreg <= '1;
      else if (fall_evt)
        shreg <= {pdat_s, shreg[WIDTH-1:1]};
    end
  end
endmodule

// File: rtl/ps2kd_keymap.sv
module ps2kd_keymap
  import ps2kd_pkg::*;
#(
  parameter int NKEYS = KEY_COUNT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_done,
  input  logic [CODE_BITS-1:0] code_byte,
  output logic                 break_pend,
  output logic [NKEYS-1:0]     keys
);
  logic is_prefix;
  assign is_prefix = (code_byte == RELEASE_PREFIX);

  always_ff @(posedge clk) begin
    if (!rst_n)          break_pend <= 1'b0;
    else if (frame_done) break_pend <= is_prefix;
  end

  generate
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
      logic match;
      assign match = frame_done && !is_prefix && (code_byte == key_code(k));
      always_ff @(posedge clk) begin
        if (!rst_n)     keys[k] <= 1'b0;
        else if (match) keys[k] <= ~break_pend;
      end
    end
  endgenerate
endmodule

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder
  import ps2kd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ps2_clk,
  input  logic ps2_data,
  output logic key_up,
  output logic key_down,
  output logic key_left,
  output logic key_right,
  output logic key_pad0,
  output logic key_space
);
  logic                 pclk_s;
  logic                 pdat_s;
  logic                 ps2_fall;
  logic                 frame_done;
  logic [CODE_BITS-1:0] code_byte;
  logic                 break_pend;
  logic [KEY_COUNT-1:0] key_vec;

  ps2kd_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .din(ps2_clk), .dout(pclk_s));

  ps2kd_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .din(ps2_data), .dout(pdat_s));

  ps2kd_framer #(.WIDTH(FRAME_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .pclk_s(pclk_s), .pdat_s(pdat_s),
    .fall_evt(ps2_fall), .frame_done(frame_done), .code_byte(code_byte));

  ps2kd_keymap #(.NKEYS(KEY_COUNT)) u_keymap (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .code_byte(code_byte),
    .break_pend(break_pend), .keys(key_vec));

  assign key_up    = key_vec[0];
  assign key_down  = key_vec[1];
  assign key_left  = key_vec[2];
  assign key_right = key_vec[3];
  assign key_pad0  = key_vec[4];
  assign key_space = key_vec[5];
endmodule

// File: rtl/ps2kd_checker.sv
module ps2kd_checker
  import ps2kd_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ps2_fall,
  input logic                 frame_done,
  input logic [CODE_BITS-1:0] code_byte,
  input logic                 break_pend,
  input logic [KEY_COUNT-1:0] keys
);
  assert_one_byte_per_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_prefix_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && code_byte == RELEASE_PREFIX) |=> break_pend);

  assert_prefix_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && code_byte != RELEASE_PREFIX) |=> !break_pend);

  assert_unknown_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && code_byte != RELEASE_PREFIX && !is_key_code(code_byte)) |=> $stable(keys));

  assert_idle_keys_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(keys));

  assert_prefix_keeps_keys_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && code_byte == RELEASE_PREFIX) |=> $stable(keys));

  generate
    for (genvar k = 0; k < KEY_COUNT; k++) begin : g_chk
      assert_make_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !break_pend && code_byte == key_code(k)) |=> keys[k]);
      assert_break_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && break_pend && code_byte == key_code(k)) |=> !keys[k]);
    end
  endgenerate
endmodule

bind ps2_key_decoder ps2kd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ps2_fall(ps2_fall), .frame_done(frame_done),
  .code_byte(code_byte), .break_pend(break_pend), .keys(key_vec));

// File: tb/ps2_key_decoder_tb.sv
module ps2_key_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ps2_clk = 1'b1;
  logic ps2_data = 1'b1;
  logic key_up, key_down, key_left, key_right, key_pad0, key_space;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [5:0] exp_keys = '0;
  logic       exp_pend = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  ps2_key_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ps2_clk(ps2_clk), .ps2_data(ps2_data),
    .key_up(key_up), .key_down(key_down), .key_left(key_left),
    .key_right(key_right), .key_pad0(key_pad0), .key_space(key_space));

  function automatic logic [7:0] tb_code(input int i);
    logic [7:0] t [6] = '{8'h75, 8'h72, 8'h6B, 8'h74, 8'h70, 8'h29};
    return t[i];
  endfunction

  function automatic bit tb_in_table(input logic [7:0] b);
    for (int i = 0; i < 6; i++) if (tb_code(i) == b) return 1'b1;
    return 1'b0;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    ps2_data = b;
    wait_cyc(4);
    ps2_clk = 1'b0;
    wait_cyc(4);
    ps2_clk = 1'b1;
    if (glitch) begin
      ps2_data = ~b;
      wait_cyc(2);
    end
  endtask

  // Frame: start 0, d0..d7, parity, stop; then update the reference model.
  task automatic send_byte(input logic [7:0] b, input bit bad_par, input bit bad_stop, input bit glitch);
    logic par;
    par = ~^b;
    if (bad_par) par = ~par;
    send_bit(1'b0, glitch);
    for (int i = 0; i < 8; i++) send_bit(b[i], glitch);
    send_bit(par, glitch);
    send_bit(bad_stop ? 1'b0 : 1'b1, glitch);
    ps2_data = 1'b1;
    wait_cyc(12);
    if (b == 8'hF0) exp_pend = 1'b1;
    else begin
      for (int k = 0; k < 6; k++) if (b == tb_code(k)) exp_keys[k] = ~exp_pend;
      exp_pend = 1'b0;
    end
  endtask

  task automatic check_keys(input string tag);
    logic [5:0] act;
    act = {key_space, key_pad0, key_right, key_left, key_down, key_up};
    tests++;
    if (act !== exp_keys) begin
      fails++;
      $display("FAIL %s: keys actual=%b expected=%b", tag, act, exp_keys);
    end
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    check_keys("R1 reset");

    // Sweep all code bytes: press, repeat, bare prefix, release.
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      bit known;
      b = v[7:0];
      if (b == 8'hF0) continue;
      known = tb_in_table(b);
      send_byte(b, v[0], (v % 3) == 0, v[1]);
      check_keys(known ? "R3 R4 make" : "R7 unknown");
      send_byte(b, 1'b0, 1'b0, 1'b0);
      check_keys(known ? "R4 repeat" : "R2 R7 unknown");
      send_byte(8'hF0, v[2], 1'b0, v[0]);
      check_keys("R5 prefix alone");
      send_byte(b, v[3], v[0], 1'b0);
      check_keys(known ? "R5 release" : "R6 R7 unknown");
    end

    // Several keys held together.
    send_byte(8'h75, 1'b0, 1'b0, 1'b0); check_keys("R8 up");
    send_byte(8'h6B, 1'b1, 1'b0, 1'b1); check_keys("R8 left");
    send_byte(8'h29, 1'b0, 1'b1, 1'b0); check_keys("R8 space");
    send_byte(8'h70, 1'b0, 1'b0, 1'b0); check_keys("R8 pad0");
    send_byte(8'hF0, 1'b0, 1'b0, 1'b0);
    send_byte(8'h6B, 1'b0, 1'b0, 1'b0); check_keys("R8 release left");
    send_byte(8'h75, 1'b0, 1'b0, 1'b0); check_keys("R4 repeat while others held");

    // Prefix consumed by an unknown byte.
    send_byte(8'hF0, 1'b0, 1'b0, 1'b0);
    send_byte(8'h1C, 1'b0, 1'b0, 1'b0); check_keys("R6 unknown after prefix");
    send_byte(8'h72, 1'b0, 1'b0, 1'b0); check_keys("R6 make after consumed prefix");
    send_byte(8'hF0, 1'b0, 1'b0, 1'b0);
    send_byte(8'h75, 1'b1, 1'b1, 1'b1); check_keys("R2 R5 release with bad bits");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule